// File: doc/BRIEF.md
# Addressed Three-Wire Serial Control Slave

This block is the control port of a chip that a host drives over three wires: chip-enable, serial clock and serial data-in. A fourth line, data-out, is open-drain. The block pulls it low or leaves it released. All three inputs are brought into the system clock domain through a synchronizer, and their edges are found there, so the serial clock must be a good deal slower than the system clock.

A transfer has two phases. While chip-enable is low, the host clocks an 8-bit address byte into the block. When chip-enable rises, the block decodes the last eight address bits. The address selects one of three modes: load control bank A, load control bank B, or read status.

In a load, 32 data bits are clocked in while chip-enable is high. The received word is written into the selected bank when chip-enable falls. In a read, a 32-bit status word from the parallel status input is captured when chip-enable rises. That word is then shifted out on data-out, most significant bit first, one bit per clock, for as many clocks as the host supplies. The meaning of the bank fields belongs to downstream logic.

Top module: `tw_ctrl_slave`

## Requirements
- R1: After a synchronous reset, both banks read zero and data-out is released (`sdo_pull_low` = 0).
- R2: Data-in is sampled on the rising serial clock. In the address phase, the first bit sent lands in address bit 0. The address sequences are: 0,0,0,1,0,0,1,0 (value 0x48) for loading bank A, 1,0,0,1,0,0,1,0 (0x49) for loading bank B, and 0,1,0,1,0,0,1,0 (0x4A) for reading.
- R3: A load-A transfer with exactly 32 data clocks writes the received word into bank A when chip-enable falls. The first data bit becomes bit 0 and the last becomes bit 31. Bank B is unchanged.
- R4: A load-B transfer with exactly 32 data clocks writes bank B in the same way and leaves bank A unchanged.
- R5: A load transfer with any data clock count other than 32 (for example 0, 1, 31, 33 or 64) leaves both banks unchanged.
- R6: Data-out stays released during a load transfer and whenever chip-enable is low.
- R7: In a read, data-out shows status bit 31 first. It moves to the next lower bit on each falling serial clock. A status bit of 0 pulls the line low and a bit of 1 releases it. After all 32 bits have been shifted out, the line stays released.
- R8: An address other than the three listed makes the block ignore the data phase: both banks are unchanged and data-out stays released.
- R9: When more than eight bits are clocked in while chip-enable is low, only the last eight form the address.
- R10: Bank contents do not change while chip-enable is high; they change only when chip-enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_ce | input | 1 | Chip-enable; low for the address phase, high for the data phase |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| status_word | input | 32 | Status value captured when a read starts |
| sdo_pull_low | output | 1 | 1 pulls the open-drain data-out line low, 0 releases it |
| bank_a | output | 32 | Control bank A |
| bank_b | output | 32 | Control bank B |

## Verification
The assertions assume that the three serial inputs are quiet for several system clocks around every edge. In particular, no serial clock edge falls in the same synchronized cycle as a chip-enable edge, and each level lasts longer than the synchronizer delay. The bench holds every serial level for eight system clocks and changes data-in only while the serial clock is low. It releases chip-enable only after a full serial clock period, so commits, mode changes and data-out updates each happen in a separate cycle.

// File: rtl/tw_ctrl_pkg.sv
package tw_ctrl_pkg;

    typedef enum logic [1:0] {
        XM_IDLE   = 2'd0,
        XM_LOAD_A = 2'd1,
        XM_LOAD_B = 2'd2,
        XM_READ   = 2'd3
    } xfer_mode_e;

    localparam int ADDR_W = 8;

    // First bit on the wire ends up in bit 0
    localparam logic [ADDR_W-1:0] ADDR_LOAD_A = 8'h48;
    localparam logic [ADDR_W-1:0] ADDR_LOAD_B = 8'h49;
    localparam logic [ADDR_W-1:0] ADDR_READ   = 8'h4A;

    function automatic xfer_mode_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_LOAD_A: return XM_LOAD_A;
            ADDR_LOAD_B: return XM_LOAD_B;
            ADDR_READ:   return XM_READ;
            default:     return XM_IDLE;
        endcase
    endfunction

    function automatic logic is_load(input xfer_mode_e m);
        return (m == XM_LOAD_A) || (m == XM_LOAD_B);
    endfunction

endpackage

// File: rtl/tw_ctrl_sync.sv
module tw_ctrl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [STAGES-1:0][WIDTH-1:0] chain;
    logic [WIDTH-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= '0;
        end else begin
            for (int s = STAGES - 1; s > 0; s--) begin
                chain[s] <= chain[s-1];
            end
            chain[0] <= raw;
            prev     <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;

endmodule

// File: rtl/tw_ctrl_frontend.sv
module tw_ctrl_frontend
    import tw_ctrl_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_lvl,
    input  logic              ce_rise,
    input  logic              ce_fall,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din_lvl,
    input  logic [WORD_W-1:0] status_word,
    output xfer_mode_e        mode,
    output logic [1:0]        commit,
    output logic [WORD_W-1:0] rx_word,
    output logic              sdo_pull_low
);

    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int CNT_SAT = WORD_W + 1;

    logic [ADDR_W-1:0] addr_sr;
    logic [WORD_W-1:0] out_sr;
    logic [CNT_W-1:0]  bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_sr      <= '0;
            out_sr       <= '1;
            rx_word      <= '0;
            bit_cnt      <= '0;
            mode         <= XM_IDLE;
            commit       <= '0;
            sdo_pull_low <= 1'b0;
        end else begin
            commit <= '0;
            if (ce_rise) begin
                mode    <= decode_addr(addr_sr);
                bit_cnt <= '0;
                out_sr  <= status_word;
            end else if (ce_fall) begin
                if (bit_cnt == CNT_W'(WORD_W)) begin
                    commit[0] <= (mode == XM_LOAD_A);
                    commit[1] <= (mode == XM_LOAD_B);
                end
                mode <= XM_IDLE;
            end else if (ce_lvl) begin
                if (sclk_rise && is_load(mode)) begin
                    rx_word <= {din_lvl, rx_word[WORD_W-1:1]};
                    if (bit_cnt != CNT_W'(CNT_SAT)) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (sclk_fall && (mode == XM_READ)) begin
                    out_sr <= {out_sr[WORD_W-2:0], 1'b1};
                end
            end else if (sclk_rise) begin
                addr_sr <= {din_lvl, addr_sr[ADDR_W-1:1]};
            end
            sdo_pull_low <= ce_lvl && (mode == XM_READ) && !out_sr[WORD_W-1];
        end
    end

endmodule

// File: rtl/tw_ctrl_banks.sv
module tw_ctrl_banks #(
    parameter int WORD_W    = 32,
    parameter int NUM_BANKS = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_BANKS-1:0]              commit,
    input  logic [WORD_W-1:0]                 word,
    output logic [NUM_BANKS-1:0][WORD_W-1:0]  banks
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                banks[b] <= '0;
            end else if (commit[b]) begin
                banks[b] <= word;
            end
        end
    end

endmodule

// File: rtl/tw_ctrl_slave.sv
module tw_ctrl_slave
    import tw_ctrl_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_ce,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic [WORD_W-1:0] status_word,
    output logic              sdo_pull_low,
    output logic [WORD_W-1:0] bank_a,
    output logic [WORD_W-1:0] bank_b
);

    localparam int LINES = 3;

    logic [LINES-1:0] lvl, rise, fall;
    logic             ce_lvl;
    xfer_mode_e       mode;
    logic [1:0]       commit;
    logic [WORD_W-1:0] rx_word;
    logic [1:0][WORD_W-1:0] banks;

    tw_ctrl_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   ({ser_din, ser_clk, ser_ce}),
        .level (lvl),
        .rise  (rise),
        .fall  (fall)
    );

    assign ce_lvl = lvl[0];

    tw_ctrl_frontend #(.WORD_W(WORD_W)) u_front (
        .clk          (clk),
        .rst          (rst),
        .ce_lvl       (ce_lvl),
        .ce_rise      (rise[0]),
        .ce_fall      (fall[0]),
        .sclk_rise    (rise[1]),
        .sclk_fall    (fall[1]),
        .din_lvl      (lvl[2]),
        .status_word  (status_word),
        .mode         (mode),
        .commit       (commit),
        .rx_word      (rx_word),
        .sdo_pull_low (sdo_pull_low)
    );

    tw_ctrl_banks #(.WORD_W(WORD_W), .NUM_BANKS(2)) u_banks (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .word   (rx_word),
        .banks  (banks)
    );

    assign bank_a = banks[0];
    assign bank_b = banks[1];

endmodule

// File: rtl/tw_ctrl_slave_chk.sv
module tw_ctrl_slave_chk
    import tw_ctrl_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         ce_lvl,
    input xfer_mode_e   mode,
    input logic [1:0]   commit,
    input logic         sdo_pull_low,
    input logic [W-1:0] bank_a,
    input logic [W-1:0] bank_b
);

    // R3, R4: a bank only changes in the cycle after its commit strobe
    assert_bank_a_commit_R3: assert property (@(posedge clk) disable iff (rst)
        (bank_a != $past(bank_a)) |-> $past(commit[0]));
    assert_bank_b_commit_R4: assert property (@(posedge clk) disable iff (rst)
        (bank_b != $past(bank_b)) |-> $past(commit[1]));

    // R10: commits only once chip-enable has gone low
    assert_commit_ce_low_R10: assert property (@(posedge clk) disable iff (rst)
        (commit != 2'b00) |-> !ce_lvl);
    assert_single_commit_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(commit));

    // R6: data-out released during loads and while chip-enable is low
    assert_open_on_load_R6: assert property (@(posedge clk) disable iff (rst)
        (ce_lvl && is_load(mode)) |=> !sdo_pull_low);
    assert_open_ce_low_R6: assert property (@(posedge clk) disable iff (rst)
        !ce_lvl |=> !sdo_pull_low);

    // R8: an unknown address keeps the line released
    assert_open_unknown_R8: assert property (@(posedge clk) disable iff (rst)
        (ce_lvl && mode == XM_IDLE) |=> !sdo_pull_low);

endmodule

bind tw_ctrl_slave tw_ctrl_slave_chk #(.W(WORD_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ce_lvl       (ce_lvl),
    .mode         (mode),
    .commit       (commit),
    .sdo_pull_low (sdo_pull_low),
    .bank_a       (bank_a),
    .bank_b       (bank_b)
);

// File: tb/tb_tw_ctrl_slave.sv
module tb_tw_ctrl_slave;

    localparam int HP = 8;
    localparam logic [7:0] A_LOAD_A = 8'h48;
    localparam logic [7:0] A_LOAD_B = 8'h49;
    localparam logic [7:0] A_READ   = 8'h4A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_ce = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_din = 1'b0;
    logic [31:0] status_word = '0;
    logic        sdo_pull_low;
    logic [31:0] bank_a, bank_b;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] exp_a = '0;
    logic [31:0] exp_b = '0;
    logic mon_open = 1'b0;
    logic saw_low  = 1'b0;
    logic done     = 1'b0;

    always #5 clk = ~clk;

    tw_ctrl_slave dut (
        .clk          (clk),
        .rst          (rst),
        .ser_ce       (ser_ce),
        .ser_clk      (ser_clk),
        .ser_din      (ser_din),
        .status_word  (status_word),
        .sdo_pull_low (sdo_pull_low),
        .bank_a       (bank_a),
        .bank_b       (bank_b)
    );

    always @(negedge clk) if (mon_open && sdo_pull_low) saw_low = 1'b1;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic pulse(input logic d);
        ser_din = d;
        wait_hp();
        ser_clk = 1'b1;
        wait_hp();
        ser_clk = 1'b0;
    endtask

    task automatic send_addr(input logic [7:0] a);
        for (int i = 0; i < 8; i++) pulse(a[i]);
        wait_hp();
    endtask

    // Load transfer; checks bank stability before chip-enable falls (R10)
    task automatic load_frame(input logic [7:0] a, input logic [31:0] w, input int n, input string req);
        send_addr(a);
        saw_low  = 1'b0;
        mon_open = 1'b1;
        ser_ce = 1'b1;
        wait_hp();
        for (int i = 0; i < n; i++) pulse(w[i % 32]);
        wait_hp();
        check(bank_a == exp_a && bank_b == exp_b, "R10 banks held while CE high", bank_a, exp_a);
        ser_ce = 1'b0;
        wait_hp();
        wait_hp();
        mon_open = 1'b0;
        if (n == 32 && a == A_LOAD_A) exp_a = w;
        if (n == 32 && a == A_LOAD_B) exp_b = w;
        check(bank_a == exp_a, {req, " bank_a"}, bank_a, exp_a);
        check(bank_b == exp_b, {req, " bank_b"}, bank_b, exp_b);
        check(!saw_low, "R6 data-out released during load", 32'(saw_low), 32'd0);
    endtask

    task automatic read_frame(input logic [31:0] st, input int n);
        status_word = st;
        send_addr(A_READ);
        ser_ce = 1'b1;
        wait_hp();
        for (int i = 0; i < n; i++) begin
            logic e;
            e = (i < 32) ? !st[31-i] : 1'b0;
            check(sdo_pull_low == e, "R7 read bit", 32'(sdo_pull_low), 32'(e));
            pulse(1'b0);
            wait_hp();
        end
        ser_ce = 1'b0;
        wait_hp();
        wait_hp();
        check(!sdo_pull_low, "R6 released after read", 32'(sdo_pull_low), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] words [5];
        int counts [5];
        logic [7:0] bad;
        words[0] = 32'hDEADBEEF; words[1] = 32'h0000_0001; words[2] = 32'h8000_0000;
        words[3] = 32'h1234_5678; words[4] = 32'hFFFF_FFFF;
        counts[0] = 0; counts[1] = 1; counts[2] = 31; counts[3] = 33; counts[4] = 64;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        check(bank_a == 0, "R1 reset bank_a", bank_a, 0);
        check(bank_b == 0, "R1 reset bank_b", bank_b, 0);
        check(!sdo_pull_low, "R1 reset data-out", 32'(sdo_pull_low), 0);

        // R2, R3: bank A loads, first bit to bit 0
        for (int k = 0; k < 5; k++) load_frame(A_LOAD_A, words[k], 32, "R3 load A");
        // R2, R4: bank B loads
        for (int k = 0; k < 5; k++) load_frame(A_LOAD_B, ~words[k] ^ 32'h0F0F_3C3C, 32, "R4 load B");

        // R5: wrong clock counts leave both banks alone
        for (int k = 0; k < 5; k++) begin
            load_frame(A_LOAD_A, 32'h5555_AAAA, counts[k], "R5 bad count A");
            load_frame(A_LOAD_B, 32'hAAAA_5555, counts[k], "R5 bad count B");
        end

        // R8: addresses one bit away from each valid one
        for (int v = 0; v < 3; v++) begin
            for (int b = 0; b < 8; b++) begin
                bad = ((v == 0) ? A_LOAD_A : (v == 1) ? A_LOAD_B : A_READ) ^ 8'(1 << b);
                if (bad != A_LOAD_A && bad != A_LOAD_B && bad != A_READ)
                    load_frame(bad, 32'h0000_0000, 32, "R8 unknown address");
            end
        end

        // R9: leading junk bits before the address
        pulse(1'b1); pulse(1'b1); pulse(1'b0);
        load_frame(A_LOAD_A, 32'hC0FF_EE01, 32, "R9 last eight bits form address");

        // R7: reads of various lengths
        read_frame(32'hDEADBEEF, 32);
        read_frame(32'h0F0F_0000, 8);
        read_frame(32'h0000_0000, 36);
        read_frame(32'hA5C3_9617, 32);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule